// File: doc/BRIEF.md
# Virtual Link Ingress Filter

This block sits on one receive port of a switch for a deterministic Ethernet network, in which each frame travels on a pre-planned virtual link rather than being forwarded by learned station addresses. Frames arrive as a byte stream with start and end markers. The block checks the 32-bit fixed prefix of the destination MAC address and takes the 16-bit virtual link number from the address's last two bytes. It uses that number to index a configuration table, and it measures the frame length as the bytes go by.

One cycle after a frame's final byte, the block gives a single-cycle verdict. An accepted frame comes with the multicast egress port mask of its link. A refused frame comes with a drop cause. The table holds, for each link, an enable bit, a largest allowed frame length and a port mask. It is loaded through a one-cycle write strobe. Writes that land while a frame is in progress are held back until that frame ends, so a frame never sees a table that changes under it.

Top module: `vl_ingress_filter`

## Requirements
- R1: The first four frame bytes, most significant first, must equal the parameter DA_PREFIX. Any mismatch drops the frame with cause 2 (address error).
- R2: The link number is byte 4 (high) and byte 5 (low) of the frame. A number whose bits at or above TBL_AW are not all zero refers to no table entry and is dropped with cause 3.
- R3: A frame whose link entry has its enable bit clear is dropped with cause 3 (unknown link). After reset every entry is disabled.
- R4: Frame length counts every byte from the start beat to the end beat inclusive. A length below 64 or above 1518 drops the frame with cause 1.
- R5: A frame longer than its link's configured largest length is dropped with cause 4.
- R6: On acceptance, dec_accept is 1, the cause is 0 and dec_ports carries the link's port mask. On a drop, dec_ports is all zero.
- R7: dec_valid pulses for exactly one cycle, in the cycle after each end beat that closes a started frame. Beats outside a frame produce no pulse. When dec_valid is low, every other output is zero.
- R8: When several faults apply, the reported cause follows this priority: length (1), then address (2), then unknown link (3), then largest length (4).
- R9: A table write issued from a frame's start beat through its end beat is held in a queue of up to PEND_DEPTH writes. Queued writes are applied in order, one per cycle outside a frame, after that frame. A write issued while idle, with no writes queued, is applied at once and is seen by a frame that starts in the next cycle.
- R10: A start beat inside an unfinished frame abandons the earlier frame without a verdict. Counting and checking restart from that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is present on in_data |
| in_sop | input | 1 | The byte is the first of a frame |
| in_eop | input | 1 | The byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| cfg_we | input | 1 | Table write strobe |
| cfg_vl | input | TBL_AW | Table entry to write |
| cfg_valid | input | 1 | Enable bit to store |
| cfg_lmax | input | LEN_W | Largest allowed frame length to store |
| cfg_ports | input | NPORT | Egress port mask to store |
| dec_valid | output | 1 | Verdict strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_drop_why | output | 3 | Drop cause: 0 none, 1 length, 2 address, 3 unknown link, 4 above largest length |
| dec_ports | output | NPORT | Egress port mask of an accepted frame |

## Verification
A miscounted length or a stale prefix flag shows up in the very next verdict as a wrong cause code, so the bench checks every frame's cause, mask and strobe. An entry that was written wrongly, or a lost queued write, only becomes visible when a later frame uses that link. For that reason the bench sends the frame that follows a deferred write on the same link. A frame-state register stuck in the wrong state would either miss a verdict or raise one from stray beats, and both show up in the cycle after the end beat.

// File: rtl/vlf_pkg.sv
package vlf_pkg;
  typedef enum logic [2:0] {
    WHY_NONE    = 3'd0,
    WHY_LENGTH  = 3'd1,
    WHY_ADDR    = 3'd2,
    WHY_UNKNOWN = 3'd3,
    WHY_LMAX    = 3'd4
  } drop_why_e;
endpackage

// File: rtl/vlf_hdr_parse.sv
module vlf_hdr_parse #(
  parameter int          LEN_W     = 11,
  parameter int          VLID_W    = 16,
  parameter int          TBL_AW    = 12,
  parameter logic [31:0] DA_PREFIX = 32'h0300_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [7:0]        in_data,
  output logic              frame_busy,
  output logic              frame_last,
  output logic [LEN_W-1:0]  len_now,
  output logic              pfx_ok_now,
  output logic [TBL_AW-1:0] vl_addr,
  output logic              vl_in_range
);
  logic              in_frame_q, in_frame_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d, cnt_base;
  logic              pfx_q, pfx_base;
  logic [VLID_W-1:0] vl_q, vl_d;
  logic [7:0]        exp_byte;
  logic              start, active, beat;

  assign start  = in_valid & in_sop;
  assign active = in_frame_q | start;
  assign beat   = in_valid & active;

  always_comb begin
    case (cnt_base[1:0])
      2'd0:    exp_byte = DA_PREFIX[31:24];
      2'd1:    exp_byte = DA_PREFIX[23:16];
      2'd2:    exp_byte = DA_PREFIX[15:8];
      default: exp_byte = DA_PREFIX[7:0];
    endcase
  end

  always_comb begin
    cnt_base   = start ? '0 : cnt_q;
    pfx_base   = start ? 1'b1 : pfx_q;
    len_now    = (&cnt_base) ? cnt_base : cnt_base + 1'b1;
    pfx_ok_now = pfx_base;
    if (cnt_base < LEN_W'(4) && in_data != exp_byte) pfx_ok_now = 1'b0;
    vl_d = vl_q;
    if (cnt_base == LEN_W'(4)) vl_d = {in_data, vl_q[7:0]};
    if (cnt_base == LEN_W'(5)) vl_d = {vl_q[VLID_W-1:8], in_data};
    cnt_d      = len_now;
    in_frame_d = ~in_eop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      pfx_q      <= 1'b0;
      vl_q       <= '0;
    end else if (beat) begin
      in_frame_q <= in_frame_d;
      cnt_q      <= cnt_d;
      pfx_q      <= pfx_ok_now;
      vl_q       <= vl_d;
    end
  end

  assign frame_busy = active;
  assign frame_last = beat & in_eop;
  assign vl_addr    = vl_q[TBL_AW-1:0];

  generate
    if (VLID_W > TBL_AW) begin : g_range
      assign vl_in_range = (vl_q[VLID_W-1:TBL_AW] == '0);
    end else begin : g_full
      assign vl_in_range = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/vlf_cfg_table.sv
module vlf_cfg_table #(
  parameter int TBL_AW     = 12,
  parameter int NPORT      = 8,
  parameter int LEN_W      = 11,
  parameter int PEND_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [TBL_AW-1:0] cfg_vl,
  input  logic              cfg_valid,
  input  logic [LEN_W-1:0]  cfg_lmax,
  input  logic [NPORT-1:0]  cfg_ports,
  input  logic              frame_busy,
  input  logic [TBL_AW-1:0] rd_addr,
  output logic              rd_valid,
  output logic [LEN_W-1:0]  rd_lmax,
  output logic [NPORT-1:0]  rd_ports,
  output logic              tbl_we
);
  localparam int ENTRIES = 1 << TBL_AW;
  localparam int PW      = (PEND_DEPTH > 1) ? $clog2(PEND_DEPTH) : 1;

  logic [LEN_W-1:0]  lmax_mem  [ENTRIES];
  logic [NPORT-1:0]  ports_mem [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  logic [TBL_AW-1:0] pq_vl    [PEND_DEPTH];
  logic              pq_valid [PEND_DEPTH];
  logic [LEN_W-1:0]  pq_lmax  [PEND_DEPTH];
  logic [NPORT-1:0]  pq_ports [PEND_DEPTH];

  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [PW:0]   cnt_q, cnt_d;
  logic          empty, full, direct, push, pop;
  logic [TBL_AW-1:0] w_addr;
  logic              w_valid;
  logic [LEN_W-1:0]  w_lmax;
  logic [NPORT-1:0]  w_ports;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == (PW+1)'(PEND_DEPTH));
  assign direct = cfg_we & ~frame_busy & empty;
  assign pop    = ~empty & ~frame_busy;
  assign push   = cfg_we & ~direct & (~full | pop);
  assign tbl_we = direct | pop;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == PW'(PEND_DEPTH-1)) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == PW'(PEND_DEPTH-1)) ? '0 : rp_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    if (pop && !push) cnt_d = cnt_q - 1'b1;
    if (direct) begin
      w_addr = cfg_vl;  w_valid = cfg_valid;
      w_lmax = cfg_lmax; w_ports = cfg_ports;
    end else begin
      w_addr = pq_vl[rp_q];   w_valid = pq_valid[rp_q];
      w_lmax = pq_lmax[rp_q]; w_ports = pq_ports[rp_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      pq_vl[wp_q]    <= cfg_vl;
      pq_valid[wp_q] <= cfg_valid;
      pq_lmax[wp_q]  <= cfg_lmax;
      pq_ports[wp_q] <= cfg_ports;
    end
    if (tbl_we) begin
      lmax_mem[w_addr]  <= w_lmax;
      ports_mem[w_addr] <= w_ports;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (tbl_we) begin
      valid_q[w_addr] <= w_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_lmax  <= '0;
      rd_ports <= '0;
    end else if (frame_busy) begin
      rd_valid <= valid_q[rd_addr];
      rd_lmax  <= lmax_mem[rd_addr];
      rd_ports <= ports_mem[rd_addr];
    end
  end
endmodule

// File: rtl/vlf_decide.sv
module vlf_decide
  import vlf_pkg::*;
#(
  parameter int NPORT   = 8,
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_last,
  input  logic [LEN_W-1:0] len_now,
  input  logic             pfx_ok,
  input  logic             vl_in_range,
  input  logic             ent_valid,
  input  logic [LEN_W-1:0] ent_lmax,
  input  logic [NPORT-1:0] ent_ports,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic [2:0]       dec_drop_why,
  output logic [NPORT-1:0] dec_ports
);
  drop_why_e        why_d;
  logic             acc_d;
  logic [NPORT-1:0] ports_d;

  always_comb begin
    if (len_now < LEN_W'(MIN_LEN) || len_now > LEN_W'(MAX_LEN)) why_d = WHY_LENGTH;
    else if (!pfx_ok)                                           why_d = WHY_ADDR;
    else if (!vl_in_range || !ent_valid)                        why_d = WHY_UNKNOWN;
    else if (len_now > ent_lmax)                                why_d = WHY_LMAX;
    else                                                        why_d = WHY_NONE;
    acc_d   = frame_last & (why_d == WHY_NONE);
    ports_d = acc_d ? ent_ports : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid    <= 1'b0;
      dec_accept   <= 1'b0;
      dec_drop_why <= 3'd0;
      dec_ports    <= '0;
    end else begin
      dec_valid    <= frame_last;
      dec_accept   <= acc_d;
      dec_drop_why <= frame_last ? why_d : 3'd0;
      dec_ports    <= ports_d;
    end
  end
endmodule

// File: rtl/vl_ingress_filter.sv
module vl_ingress_filter #(
  parameter int          NPORT      = 8,
  parameter int          TBL_AW     = 12,
  parameter int          LEN_W      = 11,
  parameter int          VLID_W     = 16,
  parameter int          PEND_DEPTH = 4,
  parameter int          MIN_LEN    = 64,
  parameter int          MAX_LEN    = 1518,
  parameter logic [31:0] DA_PREFIX  = 32'h0300_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [7:0]        in_data,
  input  logic              cfg_we,
  input  logic [TBL_AW-1:0] cfg_vl,
  input  logic              cfg_valid,
  input  logic [LEN_W-1:0]  cfg_lmax,
  input  logic [NPORT-1:0]  cfg_ports,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [2:0]        dec_drop_why,
  output logic [NPORT-1:0]  dec_ports
);
  logic              rst_s1_q, rst_s2_q;
  logic              frame_busy, frame_last, pfx_ok, vl_in_range, tbl_we;
  logic [LEN_W-1:0]  len_now, ent_lmax;
  logic [TBL_AW-1:0] vl_addr;
  logic              ent_valid;
  logic [NPORT-1:0]  ent_ports;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  vlf_hdr_parse #(
    .LEN_W(LEN_W), .VLID_W(VLID_W), .TBL_AW(TBL_AW), .DA_PREFIX(DA_PREFIX)
  ) u_hdr (
    .clk(clk), .rst_n(rst_s2_q),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .frame_busy(frame_busy), .frame_last(frame_last), .len_now(len_now),
    .pfx_ok_now(pfx_ok), .vl_addr(vl_addr), .vl_in_range(vl_in_range)
  );

  vlf_cfg_table #(
    .TBL_AW(TBL_AW), .NPORT(NPORT), .LEN_W(LEN_W), .PEND_DEPTH(PEND_DEPTH)
  ) u_tbl (
    .clk(clk), .rst_n(rst_s2_q),
    .cfg_we(cfg_we), .cfg_vl(cfg_vl), .cfg_valid(cfg_valid),
    .cfg_lmax(cfg_lmax), .cfg_ports(cfg_ports),
    .frame_busy(frame_busy), .rd_addr(vl_addr),
    .rd_valid(ent_valid), .rd_lmax(ent_lmax), .rd_ports(ent_ports),
    .tbl_we(tbl_we)
  );

  vlf_decide #(
    .NPORT(NPORT), .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)
  ) u_dec (
    .clk(clk), .rst_n(rst_s2_q),
    .frame_last(frame_last), .len_now(len_now), .pfx_ok(pfx_ok),
    .vl_in_range(vl_in_range), .ent_valid(ent_valid),
    .ent_lmax(ent_lmax), .ent_ports(ent_ports),
    .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_drop_why(dec_drop_why), .dec_ports(dec_ports)
  );
endmodule

// File: rtl/vlf_checker.sv
module vlf_checker #(
  parameter int NPORT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_eop,
  input logic             dec_valid,
  input logic             dec_accept,
  input logic [2:0]       dec_drop_why,
  input logic [NPORT-1:0] dec_ports,
  input logic             frame_busy,
  input logic             tbl_we
);
  assert_strobe_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid && in_eop));

  assert_idle_outputs_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_accept && dec_ports == '0 && dec_drop_why == 3'd0));

  assert_accept_no_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_accept) |-> (dec_drop_why == 3'd0));

  assert_drop_no_ports_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_accept) |-> (dec_ports == '0 && dec_drop_why != 3'd0));

  assert_cause_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_drop_why <= 3'd4));

  assert_table_frozen_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_busy |-> !tbl_we);
endmodule

bind vl_ingress_filter vlf_checker #(.NPORT(NPORT)) u_vlf_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eop(in_eop),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_drop_why(dec_drop_why),
  .dec_ports(dec_ports), .frame_busy(frame_busy), .tbl_we(tbl_we)
);

// File: tb/test_vl_ingress_filter.sv
module test_vl_ingress_filter;
  localparam int          NP   = 4;
  localparam int          AW   = 4;
  localparam int          NENT = 1 << AW;
  localparam logic [31:0] PFX  = 32'h0300_0000;

  logic clk, rst_n;
  logic in_valid, in_sop, in_eop;
  logic [7:0] in_data;
  logic cfg_we, cfg_valid;
  logic [AW-1:0] cfg_vl;
  logic [10:0] cfg_lmax;
  logic [NP-1:0] cfg_ports;
  logic dec_valid, dec_accept;
  logic [2:0] dec_drop_why;
  logic [NP-1:0] dec_ports;

  int total = 0, bad = 0, cycles = 0;
  bit m_valid [NENT];
  int m_lmax [NENT];
  logic [NP-1:0] m_ports [NENT];

  vl_ingress_filter #(.NPORT(NP), .TBL_AW(AW), .PEND_DEPTH(4), .DA_PREFIX(PFX)) i_vl_ingress_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .cfg_we(cfg_we), .cfg_vl(cfg_vl), .cfg_valid(cfg_valid),
    .cfg_lmax(cfg_lmax), .cfg_ports(cfg_ports), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_drop_why(dec_drop_why), .dec_ports(dec_ports));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_why(input logic [31:0] pfx, input int vl, input int len);
    if (len < 64 || len > 1518) return 1;
    if (pfx != PFX) return 2;
    if (vl >= NENT || !m_valid[vl]) return 3;
    if (len > m_lmax[vl]) return 4;
    return 0;
  endfunction

  function automatic logic [7:0] fbyte(input logic [31:0] pfx, input int vl, input int i);
    if (i < 4) return pfx[31-8*i -: 8];
    if (i == 4) return 8'(vl >> 8);
    if (i == 5) return 8'(vl);
    return 8'(i * 7);
  endfunction

  task automatic cfg_write(input int vl, input bit v, input int lmax, input logic [NP-1:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_vl = AW'(vl); cfg_valid = v; cfg_lmax = 11'(lmax); cfg_ports = p;
    @(negedge clk);
    cfg_we = 1'b0;
    m_valid[vl] = v; m_lmax[vl] = lmax; m_ports[vl] = p;
  endtask

  task automatic send_frame(input logic [31:0] pfx, input int vl, input int len, input string tag,
                            input bit mid, input int mvl, input bit mv, input int mlmax,
                            input logic [NP-1:0] mports);
    int ew;
    logic [NP-1:0] ep;
    bit spur;
    ew = exp_why(pfx, vl, len);
    ep = (ew == 0) ? m_ports[vl] : '0;
    spur = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (dec_valid) spur = 1;
      in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == len - 1);
      in_data = fbyte(pfx, vl, i);
      if (mid && i == 10) begin
        cfg_we = 1'b1; cfg_vl = AW'(mvl); cfg_valid = mv; cfg_lmax = 11'(mlmax); cfg_ports = mports;
      end else cfg_we = 1'b0;
    end
    @(negedge clk);
    chk(!spur, {tag, " R7 no pulse inside frame"}, spur, 0);
    chk(dec_valid == 1'b1, {tag, " R7 strobe"}, dec_valid, 1);
    chk(dec_drop_why == 3'(ew), {tag, " cause"}, dec_drop_why, ew);
    chk(dec_accept == (ew == 0), {tag, " accept"}, dec_accept, ew == 0);
    chk(dec_ports == ep, {tag, " ports"}, dec_ports, ep);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; cfg_we = 1'b0;
    if (mid) begin m_valid[mvl] = mv; m_lmax[mvl] = mlmax; m_ports[mvl] = mports; end
    @(negedge clk);
    chk(dec_valid == 1'b0, {tag, " R7 single cycle"}, dec_valid, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] pfx, input int vl, input int len, input string tag);
    send_frame(pfx, vl, len, tag, 1'b0, 0, 1'b0, 0, '0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
    cfg_we = 1'b0; cfg_vl = '0; cfg_valid = 1'b0; cfg_lmax = '0; cfg_ports = '0;
    for (int k = 0; k < NENT; k++) begin m_valid[k] = 0; m_lmax[k] = 0; m_ports[k] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dec_valid == 1'b0 && dec_accept == 1'b0, "R7 reset outputs", dec_valid, 0);

    // R3: every entry disabled after reset
    frame(PFX, 1, 100, "R3 empty table");

    for (int v = 0; v < NENT; v++)
      cfg_write(v, (v % 3) != 0, 100 + v * 50, NP'(v * 5 + 1));

    // Sweep all entries plus two numbers beyond the table (R2)
    for (int v = 0; v < NENT + 2; v++) begin
      int lm;
      string t;
      lm = (v < NENT) ? 100 + v * 50 : 200;
      t = (v >= NENT) ? "R2 beyond table" : (v % 3 == 0) ? "R3 disabled" : "R6 R2 sweep";
      frame(PFX, v, 64, t);
      frame(PFX, v, lm, t);
      frame(PFX, v, lm + 1, (v < NENT && v % 3 != 0) ? "R5 above lmax" : t);
    end

    // R1: a flipped bit in each prefix byte
    for (int b = 0; b < 4; b++)
      frame(PFX ^ (32'h1 << (8 * b + b)), 1, 80, "R1 prefix byte");

    // R4: global length limits
    cfg_write(2, 1'b1, 2047, 4'hA);
    frame(PFX, 2, 1, "R4 one byte");
    frame(PFX, 2, 63, "R4 short");
    frame(PFX, 2, 64, "R4 min");
    frame(PFX, 2, 1518, "R4 max");
    frame(PFX, 2, 1519, "R4 long");
    frame(PFX, 2, 1600, "R4 very long");

    // R8: priority between faults
    frame(PFX ^ 32'h100, 2, 63, "R8 length over address");
    frame(PFX ^ 32'h100, 3, 100, "R8 address over unknown");
    frame(PFX, 3, 300, "R8 unknown over lmax");

    // R9: write during a frame is deferred, then applied
    send_frame(PFX, 4, 200, "R9 deferred write", 1'b1, 4, 1'b0, 300, 4'h0);
    frame(PFX, 4, 200, "R9 applied after frame");
    send_frame(PFX, 5, 200, "R9 deferred enable", 1'b1, 6, 1'b1, 500, 4'h3);
    frame(PFX, 6, 400, "R9 enable applied");
    cfg_write(9, 1'b0, 100, 4'h1);
    frame(PFX, 9, 80, "R9 immediate write");

    // R10: restart inside an unfinished frame
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_eop = 1'b0; in_data = fbyte(PFX, 3, i);
    end
    frame(PFX, 1, 70, "R10 restart");

    // R7: stray beats outside any frame
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_eop = (i == 4); in_data = 8'(i);
    end
    @(negedge clk);
    in_valid = 1'b0; in_eop = 1'b0;
    chk(dec_valid == 1'b0, "R7 stray beats", dec_valid, 0);
    @(negedge clk);
    chk(dec_valid == 1'b0, "R7 stray beats later", dec_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule